// File: doc/BRIEF.md
# Three-Phase Inverter Gate PWM

This block produces the six gate signals for a three-leg inverter bridge: a high-side and a low-side gate per phase, plus a sync pulse at the start of every switching period. One free-running period counter is shared by all three phases. Each phase compares the counter against its own duty value to get a raw drive level. A dead-time stage then makes sure the two gates of a leg are never on together, and that both stay off for a programmed number of clocks after every change of side.

After dead time, each phase can swap its two gates (crossover). Either side can be chopped by a free-running 50% carrier with a programmable half-period. Each of the six gates has its own disable bit, and a disabled gate is held low. Configuration arrives over a plain one-cycle register write port with no back-pressure: a write is taken on every clock edge where the strobe is high, so the port has no ready signal. The period and the three duty values are double-buffered and take effect only at a period boundary. Dead time, sync width, chopping, crossover and disables act immediately.

Top module: `pwm3ph_gen`

## Requirements
- R1: The period counter counts 0 to P and wraps, where P is the active period value, so one period lasts P+1 clocks. `sync_out` is high for the first min(S, P+1) clocks of each period, where S is the sync width.
- R2: For a phase with active duty D, the raw drive is high while counter < D. With dead time 0 and 0 < D <= P, the high gate is on for D clocks and the low gate for P+1-D clocks of each period. D = 0 keeps the high gate off. D > P keeps the high gate on for the whole period.
- R3: The two gates of a phase are never high together. After each change of raw side, both gates stay off for T clocks, where T is the dead time. With 0 < D <= P, the high gate is on for max(D-T, 0) clocks per period and the low gate for max(P+1-D-T, 0) clocks.
- R4: Write-data bits 8, 7 and 6 of the output-control register enable crossover for phases 0, 1 and 2. Crossover swaps that phase's high and low gates after dead time.
- R5: Output-control bits 4/5, 2/3 and 0/1 disable the high/low gates of phases 0, 1 and 2. A disabled gate is held low. A bit value of 0 leaves the gate enabled.
- R6: Chop-register bit 8 enables chopping on the high side and bit 9 on the low side. Bits 7:0 hold C. A chopped gate is ANDed with a carrier that is high for C+1 clocks and then low for C+1 clocks. Chopping is applied after crossover.
- R7: A write to the period or a duty register does not change the period in progress. The new value applies from the next period onward.
- R8: During and after reset, all configuration is zero. While reset is held all outputs are low; after reset, with no writes, the low gates are high and the high gates and `sync_out` are low.
- R9: Register addresses: 0 period, 1 dead time (10 bits), 2 sync width (10 bits), 3/4/5 duty of phases 0/1/2, 6 chop control, 7 output control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| gate_hi | output | 3 | High-side gates, bit p for phase p |
| gate_lo | output | 3 | Low-side gates, bit p for phase p |
| sync_out | output | 1 | Period-start sync pulse |

## Verification
Gate activity is compared per period as on-clock counts over whole periods, against closed-form expectations. This makes each result independent of pipeline latency. The duty patterns cover mid-range, zero, above-period and one-clock duties. These separate plain comparison from saturation and from dead time swallowing a short pulse. A dead time longer than either half of the period separates a retriggering timer from one that lets a side through. Mixed crossover and disable patterns show which output a bit touches. Chopping is checked on a full-on gate with crossover both off and on, which shows whether chopping follows the swap. Mid-period writes to duty and period, measured in windows aligned to sync, show that buffered values wait for the boundary.

// File: rtl/pwm3ph_pkg.sv
package pwm3ph_pkg;
  localparam int NPH = 3;

  localparam logic [2:0] ADDR_PERIOD = 3'd0;
  localparam logic [2:0] ADDR_DEAD   = 3'd1;
  localparam logic [2:0] ADDR_SYNCW  = 3'd2;
  localparam logic [2:0] ADDR_DUTY0  = 3'd3;
  localparam logic [2:0] ADDR_CHOP   = 3'd6;
  localparam logic [2:0] ADDR_OUTCTL = 3'd7;

  localparam int CHOP_LO_BIT = 9;
  localparam int CHOP_HI_BIT = 8;

  // Bit position in the output-control word for each per-phase field.
  function automatic int xo_pos(int p);
    return 8 - p;
  endfunction
  function automatic int dis_hi_pos(int p);
    return 4 - 2 * p;
  endfunction
  function automatic int dis_lo_pos(int p);
    return 5 - 2 * p;
  endfunction
endpackage

// File: rtl/pwm3ph_regs.sv
module pwm3ph_regs
  import pwm3ph_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 10,
  parameter int CHOP_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic                 load,
  output logic [CNT_W-1:0]     prd_act,
  output logic [NPH*CNT_W-1:0] duty_act,
  output logic [DT_W-1:0]      dead_t,
  output logic [DT_W-1:0]      sync_w,
  output logic                 chop_hi_en,
  output logic                 chop_lo_en,
  output logic [CHOP_W-1:0]    chop_per,
  output logic [NPH-1:0]       xo,
  output logic [NPH-1:0]       dis_hi,
  output logic [NPH-1:0]       dis_lo
);
  localparam int CTL_W = 9;
  localparam int CHC_W = 10;

  logic [CNT_W-1:0] prd_buf, prd_q;
  logic [CNT_W-1:0] duty_buf [NPH];
  logic [CNT_W-1:0] duty_q   [NPH];
  logic [DT_W-1:0]  dead_q, syncw_q;
  logic [CHC_W-1:0] chop_q;
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_buf <= '0;
      prd_q   <= '0;
      dead_q  <= '0;
      syncw_q <= '0;
      chop_q  <= '0;
      ctl_q   <= '0;
      for (int p = 0; p < NPH; p++) begin
        duty_buf[p] <= '0;
        duty_q[p]   <= '0;
      end
    end else begin
      if (wr_en) begin
        case (wr_addr)
          ADDR_PERIOD: prd_buf <= wr_data;
          ADDR_DEAD:   dead_q  <= wr_data[DT_W-1:0];
          ADDR_SYNCW:  syncw_q <= wr_data[DT_W-1:0];
          ADDR_CHOP:   chop_q  <= wr_data[CHC_W-1:0];
          ADDR_OUTCTL: ctl_q   <= wr_data[CTL_W-1:0];
          default: ;
        endcase
        for (int p = 0; p < NPH; p++)
          if (wr_addr == ADDR_DUTY0 + 3'(p)) duty_buf[p] <= wr_data;
      end
      if (load) begin
        prd_q <= prd_buf;
        for (int p = 0; p < NPH; p++) duty_q[p] <= duty_buf[p];
      end
    end
  end

  always_comb begin
    prd_act    = prd_q;
    dead_t     = dead_q;
    sync_w     = syncw_q;
    chop_hi_en = chop_q[CHOP_HI_BIT];
    chop_lo_en = chop_q[CHOP_LO_BIT];
    chop_per   = chop_q[CHOP_W-1:0];
    for (int p = 0; p < NPH; p++) begin
      duty_act[p*CNT_W +: CNT_W] = duty_q[p];
      xo[p]     = ctl_q[xo_pos(p)];
      dis_hi[p] = ctl_q[dis_hi_pos(p)];
      dis_lo[p] = ctl_q[dis_lo_pos(p)];
    end
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(prd_act) && $stable(duty_act)));
endmodule

// File: rtl/pwm3ph_timebase.sv
module pwm3ph_timebase #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] prd_act,
  input  logic [DT_W-1:0]  sync_w,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             sync_s1
);
  localparam int PAD_W = CNT_W - DT_W;

  assign wrap = (cnt == prd_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sync_s1 <= 1'b0;
    end else begin
      cnt     <= wrap ? '0 : cnt + 1'b1;
      sync_s1 <= (cnt < {{PAD_W{1'b0}}, sync_w});
    end
  end

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= prd_act);
endmodule

// File: rtl/pwm3ph_phase.sv
module pwm3ph_phase #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  logic [DT_W-1:0]  dead_t,
  output logic             hi_o,
  output logic             lo_o
);
  logic            raw;
  logic            side_q;
  logic [DT_W-1:0] tmr;

  assign raw = (cnt < duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q <= 1'b0;
      tmr    <= '0;
    end else begin
      side_q <= raw;
      if (raw != side_q)   tmr <= dead_t;
      else if (tmr != '0)  tmr <= tmr - 1'b1;
    end
  end

  assign hi_o = side_q  && (tmr == '0);
  assign lo_o = !side_q && (tmr == '0);

  // R3
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(side_q) && dead_t != '0) |-> (!hi_o && !lo_o));
  // R2
  duty_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= duty) |=> !side_q);
endmodule

// File: rtl/pwm3ph_chop.sv
module pwm3ph_chop #(
  parameter int CHOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHOP_W-1:0] per,
  output logic              carrier
);
  logic [CHOP_W-1:0] cc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc      <= '0;
      carrier <= 1'b1;
    end else if (cc >= per) begin
      cc      <= '0;
      carrier <= !carrier;
    end else begin
      cc <= cc + 1'b1;
    end
  end

  // R6
  carrier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc < per) |=> $stable(carrier));
endmodule

// File: rtl/pwm3ph_gen.sv
module pwm3ph_gen
  import pwm3ph_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 10,
  parameter int CHOP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [NPH-1:0]   gate_hi,
  output logic [NPH-1:0]   gate_lo,
  output logic             sync_out
);
  logic [CNT_W-1:0]     prd_act, cnt;
  logic [NPH*CNT_W-1:0] duty_act;
  logic [DT_W-1:0]      dead_t, sync_w;
  logic                 chop_hi_en, chop_lo_en, carrier, wrap, sync_s1;
  logic [CHOP_W-1:0]    chop_per;
  logic [NPH-1:0]       xo, dis_hi, dis_lo, hi_dt, lo_dt, hi_c, lo_c;

  pwm3ph_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .CHOP_W(CHOP_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(wrap), .prd_act(prd_act), .duty_act(duty_act),
    .dead_t(dead_t), .sync_w(sync_w), .chop_hi_en(chop_hi_en),
    .chop_lo_en(chop_lo_en), .chop_per(chop_per), .xo(xo),
    .dis_hi(dis_hi), .dis_lo(dis_lo)
  );

  pwm3ph_timebase #(.CNT_W(CNT_W), .DT_W(DT_W)) tb_i (
    .clk(clk), .rst_n(rst_n), .prd_act(prd_act), .sync_w(sync_w),
    .cnt(cnt), .wrap(wrap), .sync_s1(sync_s1)
  );

  pwm3ph_chop #(.CHOP_W(CHOP_W)) chop_i (
    .clk(clk), .rst_n(rst_n), .per(chop_per), .carrier(carrier)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic hi_x, lo_x;

    pwm3ph_phase #(.CNT_W(CNT_W), .DT_W(DT_W)) ph_i (
      .clk(clk), .rst_n(rst_n), .cnt(cnt),
      .duty(duty_act[p*CNT_W +: CNT_W]), .dead_t(dead_t),
      .hi_o(hi_dt[p]), .lo_o(lo_dt[p])
    );

    assign hi_x    = xo[p] ? lo_dt[p] : hi_dt[p];
    assign lo_x    = xo[p] ? hi_dt[p] : lo_dt[p];
    assign hi_c[p] = hi_x && (!chop_hi_en || carrier);
    assign lo_c[p] = lo_x && (!chop_lo_en || carrier);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gate_hi[p] <= 1'b0;
        gate_lo[p] <= 1'b0;
      end else begin
        gate_hi[p] <= hi_c[p] && !dis_hi[p];
        gate_lo[p] <= lo_c[p] && !dis_lo[p];
      end
    end

    // R5
    dis_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_hi[p] |=> !gate_hi[p]);
    // R5
    dis_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_lo[p] |=> !gate_lo[p]);
    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[p] && gate_lo[p]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_out <= 1'b0;
    else        sync_out <= sync_s1;
  end
endmodule

// File: tb/pwm3ph_gen_tb_top.sv
module pwm3ph_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  gate_hi, gate_lo;
  logic        sync_out;

  int nchk = 0;
  int nerr = 0;
  int c_hi [3];
  int c_lo [3];
  int c_sync, c_ovl;

  always #2.5 clk = !clk;

  pwm3ph_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .sync_out(sync_out)
  );

  typedef struct packed {
    logic [15:0] prd;
    logic [15:0] dt;
    logic [15:0] d0;
    logic [15:0] d1;
    logic [15:0] d2;
    logic [15:0] sw;
    logic [15:0] ctl;
    logic [7:0]  hi0, lo0, hi1, lo1, hi2, lo2, syn;
  } vec_t;

  // Expected values are per-period on-clock counts (R1, R2, R3, R4, R5).
  localparam vec_t VECS [6] = '{
    '{16'd9,  16'd1, 16'd4, 16'd5,  16'd0, 16'd2,  16'h000, 8'd3, 8'd5, 8'd4,  8'd4, 8'd0, 8'd10, 8'd2},
    '{16'd15, 16'd2, 16'd8, 16'd20, 16'd1, 16'd3,  16'h000, 8'd6, 8'd6, 8'd16, 8'd0, 8'd0, 8'd13, 8'd3},
    '{16'd9,  16'd1, 16'd4, 16'd5,  16'd7, 16'd1,  16'h140, 8'd5, 8'd3, 8'd4,  8'd4, 8'd2, 8'd6,  8'd1},
    '{16'd9,  16'd0, 16'd3, 16'd3,  16'd3, 16'd0,  16'h012, 8'd0, 8'd7, 8'd3,  8'd7, 8'd3, 8'd0,  8'd0},
    '{16'd0,  16'd3, 16'd1, 16'd0,  16'd1, 16'd5,  16'h000, 8'd1, 8'd0, 8'd0,  8'd1, 8'd1, 8'd0,  8'd1},
    '{16'd9,  16'd6, 16'd5, 16'd5,  16'd5, 16'd10, 16'h000, 8'd0, 8'd0, 8'd0,  8'd0, 8'd0, 8'd0,  8'd10}
  };

  task automatic chk(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_win(input int n);
    for (int k = 0; k < 3; k++) begin c_hi[k] = 0; c_lo[k] = 0; end
    c_sync = 0; c_ovl = 0;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 3; k++) begin
        c_hi[k] += int'(gate_hi[k]);
        c_lo[k] += int'(gate_lo[k]);
        if (gate_hi[k] && gate_lo[k]) c_ovl++;
      end
      c_sync += int'(sync_out);
      @(negedge clk);
    end
  endtask

  task automatic wait_sync_rise();
    logic prev;
    prev = 1'b1;
    while (!(sync_out && !prev)) begin
      prev = sync_out;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int w;
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 hi in reset", int'(gate_hi), 0);
    chk("R8 lo in reset", int'(gate_lo), 0);
    chk("R8 sync in reset", int'(sync_out), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 hi after reset", int'(gate_hi), 0);
    chk("R8 lo after reset", int'(gate_lo), 7);
    chk("R8 sync after reset", int'(sync_out), 0);

    // Table walk: R1 R2 R3 R4 R5 R9
    foreach (VECS[v]) begin
      wr(3'd0, VECS[v].prd);
      wr(3'd1, VECS[v].dt);
      wr(3'd2, VECS[v].sw);
      wr(3'd3, VECS[v].d0);
      wr(3'd4, VECS[v].d1);
      wr(3'd5, VECS[v].d2);
      wr(3'd7, VECS[v].ctl);
      repeat (100) @(negedge clk);
      w = 4 * (int'(VECS[v].prd) + 1);
      count_win(w);
      chk($sformatf("R2 R9 vec%0d hi0", v), c_hi[0], 4 * int'(VECS[v].hi0));
      chk($sformatf("R3 R5 vec%0d lo0", v), c_lo[0], 4 * int'(VECS[v].lo0));
      chk($sformatf("R2 R4 vec%0d hi1", v), c_hi[1], 4 * int'(VECS[v].hi1));
      chk($sformatf("R3 vec%0d lo1", v), c_lo[1], 4 * int'(VECS[v].lo1));
      chk($sformatf("R4 R5 vec%0d hi2", v), c_hi[2], 4 * int'(VECS[v].hi2));
      chk($sformatf("R3 R5 vec%0d lo2", v), c_lo[2], 4 * int'(VECS[v].lo2));
      chk($sformatf("R1 vec%0d sync", v), c_sync, 4 * int'(VECS[v].syn));
      chk($sformatf("R3 vec%0d overlap", v), c_ovl, 0);
    end

    // R6: chopping, high side then low side, then after crossover
    wr(3'd0, 16'd9); wr(3'd1, 16'd0); wr(3'd2, 16'd1);
    wr(3'd3, 16'd15); wr(3'd4, 16'd0); wr(3'd5, 16'd15);
    wr(3'd7, 16'h000);
    wr(3'd6, 16'h101);
    repeat (50) @(negedge clk);
    count_win(40);
    chk("R6 hi chop hi0", c_hi[0], 20);
    chk("R6 hi chop lo1 untouched", c_lo[1], 40);
    chk("R6 hi chop hi2", c_hi[2], 20);
    wr(3'd6, 16'h201);
    repeat (20) @(negedge clk);
    count_win(40);
    chk("R6 lo chop hi0 untouched", c_hi[0], 40);
    chk("R6 lo chop lo1", c_lo[1], 20);
    wr(3'd7, 16'h100);
    repeat (20) @(negedge clk);
    count_win(40);
    chk("R6 chop after crossover lo0", c_lo[0], 20);
    chk("R6 chop after crossover hi0", c_hi[0], 0);
    wr(3'd6, 16'h000);
    wr(3'd7, 16'h000);

    // R7: mid-period duty write waits for the boundary
    wr(3'd1, 16'd1); wr(3'd3, 16'd4);
    repeat (50) @(negedge clk);
    wait_sync_rise();
    c_hi[0] = 0;
    for (int i = 0; i < 10; i++) begin
      c_hi[0] += int'(gate_hi[0]);
      if (i == 3) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'd8; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk("R7 duty unchanged in current period", c_hi[0], 3);
    count_win(10);
    chk("R7 duty applied next period", c_hi[0], 7);

    // R7: mid-period period write waits for the boundary
    wait_sync_rise();
    w = 0;
    do begin
      if (w == 2) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'd19; end
      else wr_en = 1'b0;
      @(negedge clk);
      w++;
    end while (!sync_out);
    wr_en = 1'b0;
    chk("R7 period unchanged in current period", w, 10);
    w = 0;
    do begin
      @(negedge clk);
      w++;
    end while (!sync_out);
    chk("R7 R1 new period length", w, 20);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule